// File: doc/BRIEF.md
# ALU with Registered Condition Flags

This block is the 16-bit arithmetic/logic stage of a small integer pipeline. Each cycle it takes two operands and a 4-bit operation code, and it computes a result with no clock in the path. In the same cycle it computes candidate values for four condition flags (zero, negative, carry, overflow), each with its own update enable.

The flags live in a register inside the block. That register loads the enabled flags on a rising clock edge when `valid_i` marks a real arithmetic instruction. The carry-consuming operations (add/subtract with carry, rotates) read the carry bit from this register. An instruction therefore sees the carry left by the instruction accepted on the previous edge.

Flag vectors are packed as bit 3 = Z, bit 2 = N, bit 1 = C, bit 0 = O.

Top module: `alu_flags`

## Requirements
- R1: After an active-low reset, `flags_o` is 4'b0000.
- R2: Codes 0000 (and), 0001 (or), 0110 (xor) and 0111 (not: inverts `opa_i`) produce the bitwise result and enable only Z and N (`flag_we_o` = 4'b1100).
- R3: Code 0010 shifts `opa_i` left one place with a zero into bit 0. Code 0011 shifts right one place with a zero into bit 15. C takes the bit shifted out (bit 15 for left, bit 0 for right). Both enable Z, N and C (4'b1110).
- R4: Code 1010 rotates `opa_i` left with the stored carry entering bit 0. Code 1011 rotates right with the stored carry entering bit 15. C takes the bit moved out, and the enable is 4'b1110.
- R5: Code 0100 gives opa+opb and code 0101 gives opa-opb. C is the carry out of opa+opb, or of opa+~opb+1 for subtract (1 = no borrow). O is set when the two addends (opb inverted for subtract) share a sign that the result does not. Both enable all four flags.
- R6: Code 1100 gives opa+opb+C and code 1101 gives opa+~opb+C, using the stored carry. They enable Z, N and C only, so O is left as it was.
- R7: Codes 1000, 1001, 1110 and 1111 give a zero result, `flag_we_o` = 0, and no flag change.
- R8: `flags_o` changes only on a rising edge with `valid_i` high. Flags whose enable is low keep their value.
- R9: Z is set exactly when the result is zero and N equals result bit 15. `flag_next_o` bits whose enable is low read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | An arithmetic instruction is present this cycle |
| op_i | input | 4 | Operation code |
| opa_i | input | 16 | First operand |
| opb_i | input | 16 | Second operand |
| result_o | output | 16 | Combinational result |
| flag_next_o | output | 4 | Candidate flag values {Z,N,C,O}, masked by enable |
| flag_we_o | output | 4 | Per-flag update enable of the current operation |
| flags_o | output | 4 | Stored flags {Z,N,C,O} |

## Verification
Two things can happen in the same cycle: the flag register takes a new carry on an edge, and a carry-consuming instruction uses that carry right after. The bench provokes this with operations placed back to back. An add that overflows 0xFFFF is followed at once by an add-with-carry, and a carry-setting subtract is followed by rotates. The bench judges the later instruction's combinational result against the carry the earlier one must have left, not against the value from before it. A second pairing loads O with an overflowing add and then issues a carry-chained add. The check is that O survives while Z, N and C are rewritten on the same edge.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;
  localparam int unsigned FLAG_W = 4;
  localparam int unsigned FZ = 3;
  localparam int unsigned FN = 2;
  localparam int unsigned FC = 1;
  localparam int unsigned FO = 0;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_OR  = 4'h1, OP_SHL = 4'h2, OP_SHR = 4'h3,
    OP_ADD = 4'h4, OP_SUB = 4'h5, OP_XOR = 4'h6, OP_NOT = 4'h7,
    OP_ROL = 4'hA, OP_ROR = 4'hB, OP_ADC = 4'hC, OP_SBC = 4'hD
  } alu_op_e;

  function automatic logic [FLAG_W-1:0] flag_mask(input logic [3:0] op);
    case (op)
      OP_AND, OP_OR, OP_XOR, OP_NOT:  flag_mask = 4'b1100;
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: flag_mask = 4'b1110;
      OP_ADC, OP_SBC:                 flag_mask = 4'b1110;
      OP_ADD, OP_SUB:                 flag_mask = 4'b1111;
      default:                        flag_mask = 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/alu_adder.sv
`timescale 1ns/1ps
module alu_adder #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         inv_b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   total;

  assign b_eff = b_i ^ {W{inv_b_i}};
  assign total = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
  assign sum_o  = total[W-1:0];
  assign cout_o = total[W];
  // signed overflow: like-signed addends, result sign differs
  assign ovf_o  = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu_shifter.sv
`timescale 1ns/1ps
module alu_shifter #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic         left_i,
  input  logic         rotate_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         out_bit_o
);
  logic fill;
  assign fill = rotate_i & cin_i;

  always_comb begin
    if (left_i) begin
      res_o     = {a_i[W-2:0], fill};
      out_bit_o = a_i[W-1];
    end else begin
      res_o     = {fill, a_i[W-1:1]};
      out_bit_o = a_i[0];
    end
  end
endmodule

// File: rtl/alu_flag_reg.sv
`timescale 1ns/1ps
module alu_flag_reg #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [N-1:0] we_i,
  input  logic [N-1:0] next_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                flags_o[i] <= 1'b0;
      else if (load_i && we_i[i]) flags_o[i] <= next_i[i];
    end
  end

  a_r8_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(flags_o));

  a_r8_masked_bits_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ((flags_o ^ $past(flags_o)) & ~$past(we_i)) == '0);
endmodule

// File: rtl/alu_flags.sv
`timescale 1ns/1ps
module alu_flags
  import alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [W-1:0]      opa_i,
  input  logic [W-1:0]      opb_i,
  output logic [W-1:0]      result_o,
  output logic [FLAG_W-1:0] flag_next_o,
  output logic [FLAG_W-1:0] flag_we_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic [W-1:0] add_sum, sh_res;
  logic         add_cout, add_ovf, sh_out;
  logic         inv_b, add_cin, sh_left, sh_rot;
  logic         c_raw, o_raw;
  logic         cf;

  assign cf = flags_o[FC];

  always_comb begin
    inv_b   = (op_i == OP_SUB) || (op_i == OP_SBC);
    add_cin = 1'b0;
    case (op_i)
      OP_SUB:         add_cin = 1'b1;
      OP_ADC, OP_SBC: add_cin = cf;
      default:        add_cin = 1'b0;
    endcase
    sh_left = (op_i == OP_SHL) || (op_i == OP_ROL);
    sh_rot  = (op_i == OP_ROL) || (op_i == OP_ROR);
  end

  alu_adder #(.W(W)) u_adder (
    .a_i(opa_i), .b_i(opb_i), .inv_b_i(inv_b), .cin_i(add_cin),
    .sum_o(add_sum), .cout_o(add_cout), .ovf_o(add_ovf)
  );

  alu_shifter #(.W(W)) u_shift (
    .a_i(opa_i), .left_i(sh_left), .rotate_i(sh_rot), .cin_i(cf),
    .res_o(sh_res), .out_bit_o(sh_out)
  );

  always_comb begin
    result_o = '0;
    c_raw    = 1'b0;
    o_raw    = 1'b0;
    case (op_i)
      OP_AND: result_o = opa_i & opb_i;
      OP_OR:  result_o = opa_i | opb_i;
      OP_XOR: result_o = opa_i ^ opb_i;
      OP_NOT: result_o = ~opa_i;
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        result_o = sh_res;
        c_raw    = sh_out;
      end
      OP_ADD, OP_SUB, OP_ADC, OP_SBC: begin
        result_o = add_sum;
        c_raw    = add_cout;
        o_raw    = add_ovf;
      end
      default: result_o = '0;
    endcase
  end

  assign flag_we_o   = flag_mask(op_i);
  assign flag_next_o = {(result_o == '0), result_o[W-1], c_raw, o_raw} & flag_we_o;

  alu_flag_reg #(.N(FLAG_W)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(valid_i),
    .we_i(flag_we_o), .next_i(flag_next_o), .flags_o(flags_o)
  );

  a_r7_unused_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i inside {4'h8, 4'h9, 4'hE, 4'hF}) |-> (result_o == '0 && flag_we_o == '0));

  a_r6_chain_keeps_o: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == OP_ADC || op_i == OP_SBC)) |=> flags_o[FO] == $past(flags_o[FO]));

  a_r2_logic_keeps_co: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i inside {OP_AND, OP_OR, OP_XOR, OP_NOT})) |=>
      flags_o[FC:FO] == $past(flags_o[FC:FO]));

  a_r9_zero_tracks_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && flag_we_o[FZ]) |=> flags_o[FZ] == ($past(result_o) == '0));

  a_r9_neg_tracks_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && flag_we_o[FN]) |=> flags_o[FN] == $past(result_o[W-1]));
endmodule

// File: tb/alu_flags_test.sv
`timescale 1ns/1ps
module alu_flags_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  op = 4'h0;
  logic [15:0] a = '0, b = '0;
  logic [15:0] result;
  logic [3:0]  fnext, fwe, flags;
  logic [3:0]  exp_flags = 4'b0000;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  alu_flags uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .opa_i(a), .opb_i(b), .result_o(result), .flag_next_o(fnext),
    .flag_we_o(fwe), .flags_o(flags)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic void model(input logic [3:0] o, input logic [15:0] x, y,
                                input logic cf, output logic [15:0] r,
                                output logic [3:0] nx, output logic [3:0] we);
    logic [16:0] s;
    logic c, v;
    c = 0; v = 0; r = '0; we = '0; s = '0;
    case (o)
      4'h0: begin r = x & y; we = 4'b1100; end
      4'h1: begin r = x | y; we = 4'b1100; end
      4'h6: begin r = x ^ y; we = 4'b1100; end
      4'h7: begin r = ~x;    we = 4'b1100; end
      4'h2: begin r = {x[14:0], 1'b0}; c = x[15]; we = 4'b1110; end
      4'h3: begin r = {1'b0, x[15:1]}; c = x[0];  we = 4'b1110; end
      4'hA: begin r = {x[14:0], cf};   c = x[15]; we = 4'b1110; end
      4'hB: begin r = {cf, x[15:1]};   c = x[0];  we = 4'b1110; end
      4'h4: begin s = {1'b0, x} + {1'b0, y}; we = 4'b1111; end
      4'h5: begin s = {1'b0, x} + {1'b0, ~y} + 17'd1; we = 4'b1111; end
      4'hC: begin s = {1'b0, x} + {1'b0, y} + {16'd0, cf}; we = 4'b1110; end
      4'hD: begin s = {1'b0, x} + {1'b0, ~y} + {16'd0, cf}; we = 4'b1110; end
      default: ;
    endcase
    if (o inside {4'h4, 4'h5, 4'hC, 4'hD}) begin
      r = s[15:0];
      c = s[16];
      if (o == 4'h4 || o == 4'hC) v = (x[15] == y[15]) && (r[15] != x[15]);
      else                        v = (x[15] != y[15]) && (r[15] != x[15]);
    end
    nx = {r == 16'd0, r[15], c, v} & we;
  endfunction

  // one instruction: drive at negedge, check comb outputs, then the stored flags
  task automatic step(input string tag, input logic [3:0] o, input logic [15:0] x, y,
                      input logic v);
    logic [15:0] r;
    logic [3:0] nx, we;
    @(negedge clk);
    op = o; a = x; b = y; valid = v;
    #1;
    model(o, x, y, exp_flags[1], r, nx, we);
    check({tag, " result"}, result, r);
    check({tag, " flag_we"}, {12'd0, fwe}, {12'd0, we});
    check({tag, " flag_next"}, {12'd0, fnext}, {12'd0, nx});
    @(posedge clk);
    #1;
    if (v) exp_flags = (exp_flags & ~we) | (nx & we);
    check({tag, " flags"}, {12'd0, flags}, {12'd0, exp_flags});
  endtask

  task automatic t_reset;
    check("R1 reset flags", {12'd0, flags}, 16'd0);
  endtask

  task automatic t_logic;
    step("R2 and", 4'h0, 16'hF0F0, 16'h0FF0, 1);
    step("R2 or", 4'h1, 16'h8000, 16'h0001, 1);
    step("R2 xor zero", 4'h6, 16'h5A5A, 16'h5A5A, 1);
    step("R9 zero flag", 4'h6, 16'h1234, 16'h1234, 1);
    check("R9 Z set", {15'd0, flags[3]}, 16'd1);
    step("R2 not", 4'h7, 16'h00FF, 16'h0000, 1);
  endtask

  task automatic t_shift;
    step("R3 shl out1", 4'h2, 16'h8001, 16'h0, 1);
    check("R3 shl C", {15'd0, flags[1]}, 16'd1);
    step("R3 shr out1", 4'h3, 16'h8001, 16'h0, 1);
    step("R3 shr out0", 4'h3, 16'h0002, 16'h0, 1);
    check("R3 shr C", {15'd0, flags[1]}, 16'd0);
  endtask

  task automatic t_addsub;
    step("R5 add ovf", 4'h4, 16'h7FFF, 16'h0001, 1);
    check("R5 add flags", {12'd0, flags}, 16'h0005);
    step("R5 sub equal", 4'h5, 16'h0005, 16'h0005, 1);
    check("R5 sub flags", {12'd0, flags}, 16'h000A);
    step("R5 sub borrow", 4'h5, 16'h0003, 16'h0005, 1);
    check("R5 borrow flags", {12'd0, flags}, 16'h0004);
    step("R5 sub ovf", 4'h5, 16'h8000, 16'h0001, 1);
  endtask

  task automatic t_rotate;
    step("R4 set C", 4'h5, 16'h0005, 16'h0005, 1);
    step("R4 rol", 4'hA, 16'h8000, 16'h0, 1);
    check("R4 rol res", result, 16'h0001);
    step("R4 ror", 4'hB, 16'h0001, 16'h0, 1);
    step("R4 ror C0", 4'hB, 16'h0100, 16'h0, 1);
    step("R4 rol C0 in", 4'hA, 16'h0101, 16'h0, 1);
  endtask

  task automatic t_chain;
    step("R6 load O", 4'h4, 16'h7FFF, 16'h0001, 1);
    step("R6 adc keeps O", 4'hC, 16'h0001, 16'h0001, 1);
    check("R6 O kept", {15'd0, flags[0]}, 16'd1);
    step("R6 carry gen", 4'h4, 16'hFFFF, 16'h0001, 1);
    step("R6 adc uses C", 4'hC, 16'h0000, 16'h0000, 1);
    step("R6 sbc C0", 4'hD, 16'h0010, 16'h0001, 1);
    step("R6 sbc C1", 4'hD, 16'h0010, 16'h0001, 1);
  endtask

  task automatic t_unused;
    step("R7 prime", 4'h5, 16'h0003, 16'h0005, 1);
    step("R7 code8", 4'h8, 16'hFFFF, 16'h1234, 1);
    step("R7 code9", 4'h9, 16'h1111, 16'h2222, 1);
    step("R7 codeE", 4'hE, 16'h8000, 16'h8000, 1);
    step("R7 codeF", 4'hF, 16'h0001, 16'h0001, 1);
    check("R7 flags held", {12'd0, flags}, 16'h0004);
  endtask

  task automatic t_idle;
    step("R8 idle add", 4'h4, 16'hFFFF, 16'h0001, 0);
    step("R8 idle shl", 4'h2, 16'h8000, 16'h0, 0);
    check("R8 flags held", {12'd0, flags}, {12'd0, exp_flags});
  endtask

  initial begin
    #12 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_logic();
    t_shift();
    t_addsub();
    t_rotate();
    t_chain();
    t_unused();
    t_idle();
    @(negedge clk) valid = 1'b0;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule